// File: doc/BRIEF.md
# Sixteen-bit two-level carry-lookahead adder

This block is a purely combinational adder of two 16-bit operands plus a carry-in. Each bit has its own cell that forms a generate bit (both operand bits set), a propagate bit (operand bits differ) and a sum bit (propagate XOR incoming carry). The bits are split into four 4-bit groups. In each group a first-level lookahead unit computes every internal carry straight from the group's generate and propagate bits and the group's carry-in, in flat AND-OR form. It also produces a group generate and a group propagate.

A second-level lookahead unit of the same shape takes the four group generate/propagate pairs and the carry-in. It produces the carries into bits 4, 8 and 12 and the final carry-out, so no carry ripples from group to group. It also reports a block generate and a block propagate. These let the whole adder serve as one group in a deeper tree. The carry-in enters at bit 0, so raising it adds one to the result.

The block has no state, so the house naming and layout are kept but no state machine exists. The only "states" are the two settled conditions of each lookahead term (kill or pass a carry). Group width and group count are parameters.

Top module: `cla16_adder`

## Requirements
- R1: `sum_out` equals bits 15..0 of the 17-bit sum `a_op + b_op + carry_in`.
- R2: `carry_out` equals bit 16 of the same 17-bit sum.
- R3: With identical operands, raising `carry_in` from 0 to 1 increases `{carry_out, sum_out}` by exactly one.
- R4: `blk_gen` is 1 exactly when `a_op + b_op` (carry-in 0) overflows 16 bits.
- R5: `blk_prop` is 1 exactly when every bit of `a_op XOR b_op` is 1, and `blk_gen` is then 0.
- R6: For k = 1, 2, 3, the carry into bit 4k (visible as `sum_out[4k] ^ a_op[4k] ^ b_op[4k]`) equals bit 4k of `a_op[4k-1:0] + b_op[4k-1:0] + carry_in`.
- R7: `carry_out` equals `blk_gen | (blk_prop & carry_in)`.
- R8: An all-propagate input (`a_op ^ b_op` = 16'hFFFF) with `carry_in` = 1 gives `sum_out` = 0 and `carry_out` = 1.
- R9: `a_op` = 16'hFFFF, `b_op` = 1, `carry_in` = 0 gives `sum_out` = 0 and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_op | input | 16 | First operand |
| b_op | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Block generate for a higher lookahead level |
| blk_prop | output | 1 | Block propagate for a higher lookahead level |

## Verification
The in-design checks are immediate assertions on settled combinational values. They assume the operands and carry-in carry no unknown bits, and they are skipped while any input is unknown. The bench drives only known values, and it changes the inputs once per clock just after the rising edge. It reads the results at the falling edge, when the adder has settled. The stimulus covers an exhaustive sweep of the lowest group (all 4-bit operand pairs with both carry-in values, upper bits zero), named corner operands and random operands.

// File: rtl/cla_pkg.sv
package cla_pkg;
    localparam int unsigned GRP_W = 4;
    localparam int unsigned GRP_N = 4;
    localparam int unsigned SUM_W = GRP_W * GRP_N;
endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell (
    input  logic x_i,
    input  logic y_i,
    input  logic c_i,
    output logic gen_o,
    output logic prop_o,
    output logic sum_o
);
    assign gen_o  = x_i & y_i;
    assign prop_o = x_i ^ y_i;
    assign sum_o  = prop_o ^ c_i;
endmodule

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
    parameter int unsigned LANES = 4
) (
    input  logic [LANES-1:0] gen_i,
    input  logic [LANES-1:0] prop_i,
    input  logic             c_in,
    output logic [LANES-1:0] c_lane_o,
    output logic             c_out,
    output logic             grp_gen_o,
    output logic             grp_prop_o
);
    logic [LANES:0] carry_w;

    // Flat two-level form: each carry is an OR of product terms.
    // Term j=0 is c_in through all lower propagates; term j>0 is gen_i[j-1].
    always_comb begin
        carry_w = '0;
        carry_w[0] = c_in;
        for (int k = 1; k <= LANES; k++) begin
            for (int j = 0; j <= k; j++) begin
                logic term;
                term = (j == 0) ? c_in : gen_i[j-1];
                for (int m = j; m < k; m++) begin
                    term = term & prop_i[m];
                end
                carry_w[k] = carry_w[k] | term;
            end
        end
    end

    always_comb begin
        grp_gen_o = 1'b0;
        for (int j = 0; j < LANES; j++) begin
            logic term;
            term = gen_i[j];
            for (int m = j + 1; m < LANES; m++) begin
                term = term & prop_i[m];
            end
            grp_gen_o = grp_gen_o | term;
        end
    end

    assign grp_prop_o = &prop_i;
    assign c_lane_o   = carry_w[LANES-1:0];
    assign c_out      = carry_w[LANES];

    // A lane cannot both generate and propagate, so a fully passing group never generates.
    always_comb begin
        if (!$isunknown({gen_i, prop_i}) && ((gen_i & prop_i) == '0)) begin
            assert_pass_excludes_gen_R5: assert (!(grp_prop_o && grp_gen_o))
                else $error("group both generates and propagates");
        end
    end
endmodule

// File: rtl/cla_group.sv
module cla_group
    import cla_pkg::*;
#(
    parameter int unsigned W = GRP_W
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         c_i,
    output logic [W-1:0] sum_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    logic [W-1:0] gen_w;
    logic [W-1:0] prop_w;
    logic [W-1:0] carry_w;
    logic         c_top_w;

    for (genvar b = 0; b < W; b++) begin : g_bit
        cla_bit_cell cell_i (
            .x_i   (x_i[b]),
            .y_i   (y_i[b]),
            .c_i   (carry_w[b]),
            .gen_o (gen_w[b]),
            .prop_o(prop_w[b]),
            .sum_o (sum_o[b])
        );
    end

    cla_lookahead #(.LANES(W)) la1_i (
        .gen_i     (gen_w),
        .prop_i    (prop_w),
        .c_in      (c_i),
        .c_lane_o  (carry_w),
        .c_out     (c_top_w),
        .grp_gen_o (grp_gen_o),
        .grp_prop_o(grp_prop_o)
    );

    // Local carry-out, unused downstream, must agree with the group summary pair.
    always_comb begin
        if (!$isunknown({x_i, y_i, c_i})) begin
            assert_group_summary_R6: assert (c_top_w == (grp_gen_o | (grp_prop_o & c_i)))
                else $error("group carry disagrees with group G/P");
            assert_group_gen_R4: assert (grp_gen_o == (({1'b0, x_i} + {1'b0, y_i}) >> W))
                else $error("group generate wrong");
        end
    end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
    import cla_pkg::*;
#(
    parameter int unsigned GW = GRP_W,
    parameter int unsigned GN = GRP_N,
    localparam int unsigned TW = GW * GN
) (
    input  logic [15:0] a_op,
    input  logic [15:0] b_op,
    input  logic        carry_in,
    output logic [15:0] sum_out,
    output logic        carry_out,
    output logic        blk_gen,
    output logic        blk_prop
);
    logic [TW-1:0] a_w;
    logic [TW-1:0] b_w;
    logic [TW-1:0] s_w;
    logic [GN-1:0] g_grp;
    logic [GN-1:0] p_grp;
    logic [GN-1:0] c_grp;

    assign a_w = TW'(a_op);
    assign b_w = TW'(b_op);

    for (genvar k = 0; k < GN; k++) begin : g_grp_inst
        cla_group #(.W(GW)) grp_i (
            .x_i       (a_w[k*GW +: GW]),
            .y_i       (b_w[k*GW +: GW]),
            .c_i       (c_grp[k]),
            .sum_o     (s_w[k*GW +: GW]),
            .grp_gen_o (g_grp[k]),
            .grp_prop_o(p_grp[k])
        );
    end

    cla_lookahead #(.LANES(GN)) la2_i (
        .gen_i     (g_grp),
        .prop_i    (p_grp),
        .c_in      (carry_in),
        .c_lane_o  (c_grp),
        .c_out     (carry_out),
        .grp_gen_o (blk_gen),
        .grp_prop_o(blk_prop)
    );

    assign sum_out = 16'(s_w);

    always_comb begin
        if (!$isunknown({a_op, b_op, carry_in})) begin
            assert_sum_matches_R1: assert ({carry_out, sum_out} == ({1'b0, a_op} + {1'b0, b_op} + 17'(carry_in)))
                else $error("sum/carry mismatch");
            assert_cout_form_R7: assert (carry_out == (blk_gen | (blk_prop & carry_in)))
                else $error("carry-out not G | P&c0");
            assert_block_prop_R5: assert (blk_prop == ((a_op ^ b_op) == 16'hFFFF))
                else $error("block propagate wrong");
        end
    end
endmodule

// File: tb/cla16_adder_tb_top.sv
module cla16_adder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] a_op = '0;
    logic [15:0] b_op = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;
    logic        blk_gen;
    logic        blk_prop;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    int unsigned cycles = 0;
    bit          drv_done = 1'b0;

    typedef struct {
        logic [15:0] a;
        logic [15:0] b;
        logic        ci;
        logic [15:0] e_sum;
        logic        e_co;
        logic        e_g;
        logic        e_p;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    cla16_adder dut_i (
        .a_op     (a_op),
        .b_op     (b_op),
        .carry_in (carry_in),
        .sum_out  (sum_out),
        .carry_out(carry_out),
        .blk_gen  (blk_gen),
        .blk_prop (blk_prop)
    );

    task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic ci, input string tag);
        item_t it;
        logic [16:0] full;
        @(posedge clk);
        #1;
        a_op = a; b_op = b; carry_in = ci;
        full = {1'b0, a} + {1'b0, b} + 17'(ci);
        it.a = a; it.b = b; it.ci = ci; it.tag = tag;
        it.e_sum = full[15:0];
        it.e_co  = full[16];
        it.e_g   = ({1'b0, a} + {1'b0, b}) >> 16 != 0;
        it.e_p   = ((a ^ b) == 16'hFFFF);
        sb_q.push_back(it);
    endtask

    task automatic fail(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_bad++;
        $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    endtask

    // Monitor: settled outputs are compared at the falling edge.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (sum_out !== it.e_sum) fail({"R1 ", it.tag}, 32'(sum_out), 32'(it.e_sum));
            if (carry_out !== it.e_co) fail({"R2 ", it.tag}, 32'(carry_out), 32'(it.e_co));
            if (blk_gen !== it.e_g) fail({"R4 ", it.tag}, 32'(blk_gen), 32'(it.e_g));
            if (blk_prop !== it.e_p) fail({"R5 ", it.tag}, 32'(blk_prop), 32'(it.e_p));
            if (carry_out !== (it.e_g | (it.e_p & it.ci))) fail({"R7 ", it.tag}, 32'(carry_out), 32'(it.e_g | (it.e_p & it.ci)));
            for (int k = 1; k < 4; k++) begin
                logic [16:0] part;
                logic        c_obs;
                part = ({1'b0, it.a} & ((17'd1 << (4*k)) - 1)) + ({1'b0, it.b} & ((17'd1 << (4*k)) - 1)) + 17'(it.ci);
                c_obs = sum_out[4*k] ^ it.a[4*k] ^ it.b[4*k];
                if (c_obs !== part[4*k]) fail({"R6 ", it.tag}, 32'(c_obs), 32'(part[4*k]));
            end
        end
    end

    initial begin
        logic [16:0] r0;
        logic [16:0] r1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        drive(16'h0000, 16'h0000, 1'b0, "zero");
        // Exhaustive lowest group
        for (int x = 0; x < 16; x++)
            for (int y = 0; y < 16; y++)
                for (int c = 0; c < 2; c++)
                    drive(16'(x), 16'(y), 1'(c), "grp0");
        drive(16'hFFFF, 16'h0001, 1'b0, "R9 ones+1");
        drive(16'hA5A5, 16'h5A5A, 1'b1, "R8 allprop");
        drive(16'hFFFF, 16'h0000, 1'b1, "R8 allprop2");
        drive(16'hFFFF, 16'hFFFF, 1'b1, "max");
        drive(16'h8000, 16'h8000, 1'b0, "msb gen");
        drive(16'h0FFF, 16'h0001, 1'b0, "group chain");
        drive(16'h00FF, 16'h0000, 1'b1, "pass8");
        for (int i = 0; i < 3000; i++)
            drive(16'($urandom), 16'($urandom), 1'($urandom), "random");
        // R3: carry-in adds one, checked as a difference of two settled results
        for (int i = 0; i < 40; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = (i == 0) ? 16'hFFFF : 16'($urandom);
            rb = (i == 0) ? 16'h0000 : 16'($urandom);
            drive(ra, rb, 1'b0, "R3 c0=0");
            @(negedge clk); #1;
            r0 = {carry_out, sum_out};
            drive(ra, rb, 1'b1, "R3 c0=1");
            @(negedge clk); #1;
            r1 = {carry_out, sum_out};
            n_vec++;
            if (r1 !== r0 + 17'd1) fail("R3 increment", 32'(r1), 32'(r0 + 17'd1));
        end
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        drv_done = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (drv_done && sb_q.size() == 0) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule